// File: doc/BRIEF.md
# Temperature Word to Fahrenheit Hundredths Converter

This block turns a thermometer's raw reading into a signed temperature in hundredths of a degree Fahrenheit. A single start strobe delivers three operands. The first is a two's-complement temperature word whose least significant bit stands for half a degree Celsius. The second is a residual count, and the third is a count-per-degree value. The block first takes the whole-degree Celsius value and scales it by 180. It then applies a fixed offset that combines the 0.75 °C correction with the 32 °F shift. Last, it subtracts the fractional refinement, which is the residual times 180 divided by the count-per-degree.

The fractional quotient comes from an iterative restoring divider, so every conversion takes a fixed number of cycles. A one-cycle done pulse marks the arrival of a new result, and the result output holds that value until the next conversion completes. If the count-per-degree is zero, no division takes place. In that case the block returns at once with an error flag.

Top module: `temp_fahr_conv`

## Requirements
- R1: After reset, done_o, err_o and busy_o are 0, and result_o is 0.
- R2: When start_i is accepted with a nonzero count-per-degree, done_o is 1 for exactly one cycle, 17 clock edges after the accepting edge (with the default 8-bit residual). It is not 1 in any cycle before that.
- R3: For a non-negative word, result_o on done is C*180 - 135 + 3200 - floor(resid_i*180/per_deg_i). Here C is raw_i shifted right by one bit.
- R4: raw_i is two's complement with bit 15 as the sign. C is an arithmetic shift, so negative words give negative degrees, down to raw_i = 16'h8000.
- R5: Bit 0 of raw_i has no effect on the result. Words 2k and 2k+1 give equal results.
- R6: The fractional term truncates toward zero. This holds over the full residual range, including per_deg_i = 1 with resid_i = 255, and resid_i = 0.
- R7: An accepted start with per_deg_i = 0 gives done_o = 1 and err_o = 1 on the next edge, with result_o = 0. err_o is 1 only together with done_o.
- R8: A start_i while busy_o is 1 is ignored. It produces no extra done pulse and does not change the result of the conversion in progress.
- R9: busy_o is 1 from the edge that accepts a valid start until the edge that raises done_o. It is 0 in the done cycle.
- R10: result_o changes only in cycles where done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| raw_i | input | 16 | Signed temperature word, LSB = 0.5 °C |
| resid_i | input | 8 | Residual count |
| per_deg_i | input | 8 | Count-per-degree |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| err_o | output | 1 | Zero count-per-degree, pulses with done_o |
| result_o | output | 25 | Signed temperature, hundredths of °F |

## Verification
The assertions check the protocol rules on every cycle. done_o is a single-cycle strobe that never overlaps busy_o. err_o appears only with done_o and a zero result. result_o holds between strobes. A conversion never stays busy longer than the divider's iteration count. The numeric value of the result cannot be checked by these rules. Whether it matches the formula for positive, negative, odd and extreme words, whether the division truncates, and whether a start while busy is ignored can only be shown by the bench's scenarios against its reference model.

// File: rtl/temp_conv_pkg.sv
package temp_conv_pkg;
  localparam int unsigned FAHR_SCALE = 180;             // hundredths of F per degree C
  localparam int          FIXED_OFS  = 3200 - 135;      // +32 F, -0.75 C
  localparam int unsigned SCALE_W    = $clog2(FAHR_SCALE + 1);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } conv_state_e;
endpackage

// File: rtl/const_scale_mul.sv
module const_scale_mul #(
  parameter int unsigned IN_W   = 8,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned MULT   = 180,
  parameter int unsigned MULT_W = 8,
  parameter bit          SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  x_i,
  output logic [OUT_W-1:0] p_o
);
  logic [OUT_W-1:0] x_ext;
  logic [OUT_W-1:0] part [MULT_W];

  generate
    if (SIGNED) begin : g_sext
      assign x_ext = {{(OUT_W-IN_W){x_i[IN_W-1]}}, x_i};
    end else begin : g_zext
      assign x_ext = {{(OUT_W-IN_W){1'b0}}, x_i};
    end
    for (genvar b = 0; b < MULT_W; b++) begin : g_part
      localparam logic [31:0] MBITS = MULT;
      if (MBITS[b]) begin : g_on
        assign part[b] = x_ext << b;
      end else begin : g_off
        assign part[b] = '0;
      end
    end
  endgenerate

  always_comb begin
    p_o = '0;
    for (int i = 0; i < MULT_W; i++) p_o = p_o + part[i];
  end
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             valid_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign fits    = ~trial[DEN_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        den_q <= den_i;
        quo_q <= num_i;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        // remainder stays below divisor, so DEN_W bits suffice
        rem_q <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q   <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/temp_fahr_conv.sv
module temp_fahr_conv
  import temp_conv_pkg::*;
#(
  parameter int unsigned RAW_W   = 16,
  parameter int unsigned RESID_W = 8,
  parameter int unsigned RES_W   = RAW_W + 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [RAW_W-1:0]        raw_i,
  input  logic [RESID_W-1:0]      resid_i,
  input  logic [RESID_W-1:0]      per_deg_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic signed [RES_W-1:0] result_o
);
  localparam int unsigned NUM_W = RESID_W + SCALE_W;
  localparam int unsigned DEG_W = RAW_W - 1;

  conv_state_e      state_q;
  logic [RES_W-1:0] base_q;
  logic [RES_W-1:0] coarse_scaled;
  logic [NUM_W-1:0] frac_num;
  logic [NUM_W-1:0] quo;
  logic             div_valid;
  logic             accept, div_load, zero_den;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign zero_den = (per_deg_i == '0);
  assign div_load = accept && !zero_den;

  // whole degrees: drop the half-degree bit, keep sign
  const_scale_mul #(
    .IN_W(DEG_W), .OUT_W(RES_W), .MULT(FAHR_SCALE), .MULT_W(SCALE_W), .SIGNED(1'b1)
  ) u_coarse_mul (
    .x_i(raw_i[RAW_W-1:1]),
    .p_o(coarse_scaled)
  );

  const_scale_mul #(
    .IN_W(RESID_W), .OUT_W(NUM_W), .MULT(FAHR_SCALE), .MULT_W(SCALE_W), .SIGNED(1'b0)
  ) u_frac_mul (
    .x_i(resid_i),
    .p_o(frac_num)
  );

  restoring_div #(
    .NUM_W(NUM_W), .DEN_W(RESID_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (div_load),
    .num_i  (frac_num),
    .den_i  (per_deg_i),
    .quo_o  (quo),
    .valid_o(div_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (zero_den) begin
              done_o   <= 1'b1;
              err_o    <= 1'b1;
              result_o <= '0;
            end else begin
              base_q  <= coarse_scaled + RES_W'(FIXED_OFS);
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (div_valid) begin
            result_o <= $signed(base_q - {{(RES_W-NUM_W){1'b0}}, quo});
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
endmodule

// File: rtl/temp_fahr_conv_chk.sv
module temp_fahr_conv_chk #(
  parameter int unsigned RAW_W   = 16,
  parameter int unsigned RESID_W = 8,
  parameter int unsigned RES_W   = RAW_W + 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    err_o,
  input logic signed [RES_W-1:0] result_o
);
  localparam int unsigned MAX_BUSY = RESID_W + temp_conv_pkg::SCALE_W;
  logic [31:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= '0;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && result_o == '0));
  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R2
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= MAX_BUSY + 1);
  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && busy_cnt < MAX_BUSY) |=> busy_o);
endmodule

bind temp_fahr_conv temp_fahr_conv_chk #(
  .RAW_W(RAW_W), .RESID_W(RESID_W), .RES_W(RES_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .result_o(result_o)
);

// File: tb/temp_fahr_conv_tb.sv
`timescale 1ns/1ps
module temp_fahr_conv_tb;
  localparam int RES_W = 25;
  localparam int LAT   = 17;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [15:0] raw = '0;
  logic [7:0]  resid = '0, per = '0;
  logic busy, done, err;
  logic signed [RES_W-1:0] result;

  int n_chk = 0, n_fail = 0;
  int m_cd = 0, m_res = 0, m_pend = 0;
  bit m_done = 0, m_err = 0, m_busy = 0;
  string req = "R1";
  int done_seen = 0;

  always #4 clk = ~clk;

  temp_fahr_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .raw_i(raw),
    .resid_i(resid), .per_deg_i(per), .busy_o(busy), .done_o(done),
    .err_o(err), .result_o(result)
  );

  function automatic int expect_f(logic [15:0] r, logic [7:0] rs, logic [7:0] pd);
    int c;
    c = int'($signed(r));
    c = c >>> 1;
    return c * 180 - 135 + 3200 - (int'(rs) * 180) / int'(pd);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: apply inputs, step model, compare
  task automatic cyc(bit s, logic [15:0] r, logic [7:0] rs, logic [7:0] pd);
    start = s; raw = r; resid = rs; per = pd;
    @(posedge clk); #1;
    m_done = 0; m_err = 0;
    if (m_cd > 0) begin
      m_cd--;
      if (m_cd == 0) begin m_done = 1; m_busy = 0; m_res = m_pend; end
    end else if (s) begin
      if (pd == 0) begin m_done = 1; m_err = 1; m_res = 0; end
      else begin m_cd = LAT; m_busy = 1; m_pend = expect_f(r, rs, pd); end
    end
    chk({req, "/R2 done"}, int'(done), int'(m_done));
    chk({req, "/R7 err"}, int'(err), int'(m_err));
    chk({req, "/R9 busy"}, int'(busy), int'(m_busy));
    chk({req, "/R10 result"}, int'(result), m_res);
    if (done) done_seen++;
  endtask

  task automatic run(string tag, logic [15:0] r, logic [7:0] rs, logic [7:0] pd);
    req = tag;
    cyc(1, r, rs, pd);
    for (int i = 0; i < LAT + 1; i++) cyc(0, '0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r_even, r_odd;
    #20;
    // R1 reset values
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 result", int'(result), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) cyc(0, '0, '0, '0);

    run("R3", 16'h0032, 8'd12, 8'd16);     // 25 C
    chk("R3 value", int'(result), 7430);
    run("R3", 16'h00AA, 8'd5, 8'd16);
    run("R4", 16'hFFCE, 8'd12, 8'd16);     // -25 C
    chk("R4 value", int'(result), -4500 - 135 + 3200 - 135);
    run("R4", 16'h8000, 8'd0, 8'd16);
    chk("R4 min", int'(result), -16384 * 180 + 3065);
    run("R5", 16'h0033, 8'd7, 8'd16);
    r_odd = int'(result);
    run("R5", 16'h0032, 8'd7, 8'd16);
    r_even = int'(result);
    chk("R5 lsb ignored", r_odd, r_even);
    run("R6", 16'h0010, 8'd255, 8'd1);
    chk("R6 max frac", int'(result), 8 * 180 + 3065 - 45900);
    run("R6", 16'h0010, 8'd1, 8'd7);       // 180/7 = 25
    chk("R6 trunc", int'(result), 1440 + 3065 - 25);
    run("R6", 16'h0010, 8'd0, 8'd200);
    run("R7", 16'h0040, 8'd3, 8'd0);

    // R8: starts while busy are ignored
    req = "R8";
    done_seen = 0;
    cyc(1, 16'h0064, 8'd4, 8'd16);
    for (int i = 0; i < 5; i++) cyc(1, 16'hFF00, 8'd9, 8'd3);
    for (int i = 0; i < LAT; i++) cyc(0, '0, '0, '0);
    chk("R8 one done", done_seen, 1);
    chk("R8 value", int'(result), expect_f(16'h0064, 8'd4, 8'd16));

    // back-to-back: start in the done cycle's following cycle
    req = "R2";
    cyc(1, 16'h0020, 8'd2, 8'd16);
    for (int i = 0; i < LAT - 1; i++) cyc(0, '0, '0, '0);
    cyc(1, 16'h0022, 8'd3, 8'd16);
    cyc(1, 16'h0024, 8'd4, 8'd16);
    for (int i = 0; i < LAT + 2; i++) cyc(0, '0, '0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule